// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block holds one general register of a timer channel and the I/O pin that belongs to it. A free-running counter elsewhere in the timer supplies its count value. A 4-bit control code chooses the mode. In compare mode, the code sets the level the pin starts at and whether the output driver is enabled. It also sets what a match between the counter and the register does to the pin: drive it low, drive it high, or invert it. In capture mode, the code chooses which pin transitions copy the counter value into the register: rising, falling, or both.

Software writes the control code or the general register through a one-cycle write strobe with a select bit, and reads both back on dedicated outputs. A buffer-mode input turns the register into a plain buffer, and then no compare or capture activity takes place. Two event strobes report matches and captures to the rest of the timer.

Top module: `tcc_channel`

## Requirements
- R1: After reset, the control code reads 0, the general register reads 0, pin_o is 0, pin_oe_o is 0, and both event strobes are 0.
- R2: Codes 4'b0000 and 4'b0100 make a compare register with the pin driver disabled. One edge after such a write, pin_oe_o is 0 and pin_o is 0, and a compare match does not change the pin.
- R3: Codes 4'b0001, 4'b0010 and 4'b0011 start the pin low. On the clock edge that stores the code, pin_oe_o becomes 1 and pin_o becomes 0.
- R4: Codes 4'b0101, 4'b0110 and 4'b0111 start the pin high. On the clock edge that stores the code, pin_oe_o becomes 1 and pin_o becomes 1.
- R5: match_o is 1 in every cycle where code bit 3 is 0, buf_mode_i is 0 and cnt_i equals the register. If the driver is enabled, the next edge applies the action in code bits [1:0]: 01 gives low, 10 gives high, 11 inverts the pin.
- R6: A code with bit 3 set selects capture mode. Bit 2 is ignored, and pin_oe_o is 0 while capture mode is active.
- R7: pin_i passes through two synchroniser flops. In capture mode, code bits [1:0]=00 select rising transitions, 01 selects falling transitions, and 1x selects both. capt_o is 1 for one cycle, in the cycle after the second synchroniser flop takes the new level.
- R8: On the edge that ends a capt_o cycle, the register takes the value cnt_i had during that cycle.
- R9: While buf_mode_i is 1, match_o and capt_o stay 0, and the pin and the register change only through software writes.
- R10: A software write to the register updates it in any mode. If a capture occurs in the same cycle, the captured count is stored instead.
- R11: A control write in the same cycle as a compare match sets the pin from the new code's start level, and the match action is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Free-running counter value |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the control code, 1 selects the general register |
| wr_data_i | input | CNT_W | Write data; the control code uses bits [3:0] |
| buf_mode_i | input | 1 | Buffer mode; suppresses capture and compare |
| pin_i | input | 1 | Asynchronous pin input |
| ctrl_o | output | 4 | Control code read-back |
| gr_o | output | CNT_W | General register read-back |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin output enable |
| match_o | output | 1 | Compare-match strobe |
| capt_o | output | 1 | Capture strobe |

## Verification
The assertions assume that rst_n is held low for at least one edge before any check counts. They also assume that software writes arrive as single-cycle strobes whose data is stable at the sampling edge. The bench drives every input one time unit after the rising edge, so every edge sees settled values. The counter advances by one each cycle, and pin_i changes at intervals that also let the synchroniser resolve each transition. Writes to the register and control writes are placed on and around match and capture cycles, so that the same-cycle priorities are exercised.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic     is_capt;
    logic     out_en;
    logic     init_lvl;
    pin_act_e act;
    logic     cap_rise;
    logic     cap_fall;
  } chan_mode_t;

  function automatic chan_mode_t decode_mode(input logic [3:0] code);
    chan_mode_t m;
    m.is_capt  = code[3];
    m.out_en   = !code[3] && (code[1:0] != 2'b00);
    m.init_lvl = !code[3] && code[2];
    m.act      = code[3] ? ACT_NONE : pin_act_e'(code[1:0]);
    m.cap_rise = code[3] && (code[1] || !code[0]);
    m.cap_fall = code[3] && (code[1] || code[0]);
    return m;
  endfunction

  function automatic logic pin_after_match(input pin_act_e a, input logic cur);
    case (a)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_TOG:  return !cur;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pin_i;
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign rise_o = chain_q[LAST-1] && !chain_q[LAST];
  assign fall_o = !chain_q[LAST-1] && chain_q[LAST];

endmodule

// File: rtl/tcc_gr_reg.sv
module tcc_gr_reg
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sw_wr_i,
  input  logic [CNT_W-1:0] sw_data_i,
  input  logic             buf_i,
  input  chan_mode_t       mode_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] gr_o,
  output logic             match_o,
  output logic             capt_o
);
  logic [CNT_W-1:0] gr_q;
  logic             edge_sel;

  assign edge_sel = (rise_i && mode_i.cap_rise) || (fall_i && mode_i.cap_fall);
  assign capt_o   = !buf_i && mode_i.is_capt && edge_sel;
  assign match_o  = !buf_i && !mode_i.is_capt && (cnt_i == gr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       gr_q <= '0;
    else if (capt_o)  gr_q <= cnt_i;
    else if (sw_wr_i) gr_q <= sw_data_i;
  end

  assign gr_o = gr_q;

  AST_CAPT_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    capt_o |=> gr_q == $past(cnt_i)); // R8

  AST_BUF_HOLDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_i && !sw_wr_i) |=> gr_q == $past(gr_q)); // R9

endmodule

// File: rtl/tcc_pin_ctl.sv
module tcc_pin_ctl
  import tcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr_i,
  input  chan_mode_t new_mode_i,
  input  chan_mode_t cur_mode_i,
  input  logic       match_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  logic pin_q, oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (ctrl_wr_i) begin
      oe_q  <= new_mode_i.out_en;
      pin_q <= new_mode_i.out_en && new_mode_i.init_lvl;
    end else if (match_i && cur_mode_i.out_en) begin
      pin_q <= pin_after_match(cur_mode_i.act, pin_q);
    end
  end

  assign pin_o    = pin_q;
  assign pin_oe_o = oe_q;

  AST_INIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && new_mode_i.out_en) |=> pin_oe_o && (pin_o == $past(new_mode_i.init_lvl))); // R3

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && cur_mode_i.out_en && cur_mode_i.act == ACT_TOG && !ctrl_wr_i)
      |=> pin_o != $past(pin_o)); // R5

  AST_NO_DRIVE_IN_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode_i.is_capt |-> !pin_oe_o); // R6

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             buf_mode_i,
  input  logic             pin_i,
  output logic [3:0]       ctrl_o,
  output logic [CNT_W-1:0] gr_o,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             match_o,
  output logic             capt_o
);
  localparam int CODE_W = 4;

  logic [CODE_W-1:0] ctrl_q;
  logic              ctrl_wr, gr_wr;
  chan_mode_t        cur_mode, new_mode;
  logic              rise_w, fall_w;
  logic              match_w, capt_w;

  assign ctrl_wr  = wr_en_i && !wr_sel_i;
  assign gr_wr    = wr_en_i && wr_sel_i;
  assign cur_mode = decode_mode(ctrl_q);
  assign new_mode = decode_mode(wr_data_i[CODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wr_data_i[CODE_W-1:0];
  end

  tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  tcc_gr_reg #(.CNT_W(CNT_W)) u_gr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_i),
    .sw_wr_i   (gr_wr),
    .sw_data_i (wr_data_i),
    .buf_i     (buf_mode_i),
    .mode_i    (cur_mode),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .gr_o      (gr_o),
    .match_o   (match_w),
    .capt_o    (capt_w)
  );

  tcc_pin_ctl u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr_i  (ctrl_wr),
    .new_mode_i (new_mode),
    .cur_mode_i (cur_mode),
    .match_i    (match_w),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
  );

  assign ctrl_o  = ctrl_q;
  assign match_o = match_w;
  assign capt_o  = capt_w;

  AST_BUF_SILENCES_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode_i |-> !match_o && !capt_o); // R9

endmodule

// File: tb/tcc_channel_tb.sv
module tcc_channel_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_i = '0;
  logic         wr_en_i = 1'b0;
  logic         wr_sel_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         buf_mode_i = 1'b0;
  logic         pin_i = 1'b0;
  logic [3:0]   ctrl_o;
  logic [W-1:0] gr_o;
  logic         pin_o, pin_oe_o, match_o, capt_o;

  always #2 clk = !clk;

  tcc_channel #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .buf_mode_i(buf_mode_i),
    .pin_i(pin_i), .ctrl_o(ctrl_o), .gr_o(gr_o), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .match_o(match_o), .capt_o(capt_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string req = "R1";

  // behavioural reference state
  int m_ctrl = 0, m_gr = 0, m_pin = 0, m_oe = 0;
  int sy[3] = '{0, 0, 0};

  function automatic int exp_match();
    if (buf_mode_i) return 0;
    if ((m_ctrl / 8) % 2 == 1) return 0;
    return (int'(cnt_i) == m_gr) ? 1 : 0;
  endfunction

  function automatic int exp_capt();
    int lo;
    bit up, dn;
    if (buf_mode_i || (m_ctrl / 8) % 2 == 0) return 0;
    lo = m_ctrl % 4;
    up = (sy[1] == 1) && (sy[2] == 0);
    dn = (sy[1] == 0) && (sy[2] == 1);
    if (lo >= 2) return (up || dn) ? 1 : 0;
    if (lo == 0) return up ? 1 : 0;
    return dn ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int mt, cp, d;
    cycles++;
    if (!rst_n) begin
      m_ctrl = 0; m_gr = 0; m_pin = 0; m_oe = 0;
      sy[0] = 0; sy[1] = 0; sy[2] = 0;
    end else begin
      mt = exp_match();
      cp = exp_capt();
      d  = int'(wr_data_i);
      if (cp == 1)                  m_gr = int'(cnt_i);
      else if (wr_en_i && wr_sel_i) m_gr = d;
      if (wr_en_i && !wr_sel_i) begin
        m_ctrl = d % 16;
        m_oe   = (m_ctrl < 8 && m_ctrl % 4 != 0) ? 1 : 0;
        m_pin  = m_oe ? (m_ctrl / 4) % 2 : 0;
      end else if (mt == 1 && m_oe == 1) begin
        case (m_ctrl % 4)
          1: m_pin = 0;
          2: m_pin = 1;
          3: m_pin = 1 - m_pin;
          default: ;
        endcase
      end
      sy[2] = sy[1]; sy[1] = sy[0]; sy[0] = pin_i ? 1 : 0;
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("ctrl_o",   int'(ctrl_o),   m_ctrl);
      cmp("gr_o",     int'(gr_o),     m_gr);
      cmp("pin_o",    int'(pin_o),    m_pin);
      cmp("pin_oe_o", int'(pin_oe_o), m_oe);
      cmp("match_o",  int'(match_o),  exp_match());
      cmp("capt_o",   int'(capt_o),   exp_capt());
    end
  end

  // free-running counter
  always begin
    @(posedge clk); #1;
    cnt_i = cnt_i + 1'b1;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input bit sel, input logic [W-1:0] d);
    @(posedge clk); #1;
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  // arm a compare a few cycles ahead and let it fire
  task automatic run_compare(input logic [3:0] code, input int ahead);
    wr(1'b0, {12'h0, code});
    tick(2);
    wr(1'b1, cnt_i + W'(ahead));
    tick(ahead + 4);
  endtask

  task automatic pulse_pin(input int gap);
    pin_i = !pin_i; tick(gap);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    // R1: reset state, checked on the first compare cycles
    req = "R1"; tick(3);
    if (ctrl_o != 4'h0 || pin_oe_o) begin
      n_bad++; $display("FAIL R1 ctrl_o=%0d oe=%0d expected 0/0", ctrl_o, pin_oe_o);
    end
    n_cmp++;

    req = "R3";
    run_compare(4'b0001, 5); run_compare(4'b0010, 4);
    run_compare(4'b0011, 3); run_compare(4'b0011, 6);
    req = "R4";
    run_compare(4'b0101, 5); run_compare(4'b0110, 4); run_compare(4'b0111, 3);
    req = "R2";
    run_compare(4'b0000, 4); run_compare(4'b0100, 4);
    req = "R5";
    wr(1'b0, 16'h0003);
    for (int k = 0; k < 6; k++) begin
      wr(1'b1, cnt_i + W'(2 + k)); tick(3 + k);
    end
    // R11: control write landing on the match cycle
    req = "R11";
    for (int k = 1; k < 4; k++) begin
      wr(1'b0, 16'h0007); tick(1);
      wr(1'b1, cnt_i + W'(k + 1));
      tick(k - 1);
      wr(1'b0, 16'h0001); tick(4);
    end
    // R6 / R7 / R8: capture codes, bit 2 both ways
    req = "R7";
    foreach (dut_caps[i]) begin
      wr(1'b0, {12'h0, dut_caps[i]});
      for (int e = 0; e < 6; e++) pulse_pin(4 + e);
      req = (i % 2 == 0) ? "R8" : "R6";
    end
    // R10: software writes racing captures
    req = "R10";
    wr(1'b0, 16'h000A);
    for (int k = 0; k < 6; k++) begin
      pin_i = !pin_i;
      tick(k % 3);
      wr(1'b1, 16'hA5A0 + W'(k));
      tick(4);
    end
    // R9: buffer mode silences both kinds of event
    req = "R9";
    buf_mode_i = 1'b1;
    for (int e = 0; e < 4; e++) pulse_pin(5);
    wr(1'b0, 16'h0003);
    wr(1'b1, cnt_i + W'(3)); tick(8);
    buf_mode_i = 1'b0;
    wr(1'b1, cnt_i + W'(3)); tick(8);
    // mixed traffic
    req = "R5";
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1;
      wr_en_i    = ($urandom % 5 == 0);
      wr_sel_i   = $urandom % 2;
      wr_data_i  = wr_sel_i ? cnt_i + W'($urandom % 6) : W'($urandom % 16);
      buf_mode_i = ($urandom % 9 == 0);
      if ($urandom % 4 == 0) pin_i = !pin_i;
    end
    @(posedge clk); #1;
    wr_en_i = 1'b0; buf_mode_i = 1'b0;
    tick(4);
    finish_run();
  end

  logic [3:0] dut_caps [5] = '{4'b1000, 4'b1101, 4'b1010, 4'b1111, 4'b1100};

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cycles > 50000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog %s actual=%0d expected<50000 cycles", req, cycles);
    finish_run();
  end

endmodule